// File: doc/BRIEF.md
# Prescaled 16-bit Multi-Mode Timer

This block is a 16-bit up-counter, or up/down counter, that a small microcontroller reads and controls through an 8-bit register port. A tick enable arrives from outside. A two-bit prescaler select turns that tick into a counter update on every tick, or on every 8th, 32nd or 128th tick. A two-bit mode field chooses one of four behaviours. The counter can hold its value, run freely across the full 16-bit range, count modulo a period value given on an input port, or count up to that period and back down again.

Software reads the 16-bit count as two bytes. Reading the low byte takes a copy of the high byte, so reading the high byte afterwards gives a value that matches the low byte already read. Writing any data to the low byte clears the counter and sends a one-cycle reinitialise strobe to the compare/output channels next to the timer. Each time the counter wraps or returns to zero, the block emits a one-cycle terminal-count pulse.

Top module: `tmr16_top`

## Requirements
- R1: The control register is at address 0. Bits 1:0 hold the mode and bits 3:2 hold the prescaler select. Bits 7:4 always read as zero. After reset every field is zero.
- R2: Reading the low count byte (address 1) returns the live count bits 7:0. On that same cycle it copies count bits 15:8 into a buffer. Reading the high count byte (address 2) returns the buffer, not the live count.
- R3: A write to address 1, with any data, sets the count to 0x0000. `reinit_o` goes high for exactly the one cycle after that write. A write to address 2 changes nothing.
- R4: The prescaler select sets how many ticks make one counter update: 00 needs 1 tick, 01 needs 8, 10 needs 32 and 11 needs 128.
- R5: Mode 00 holds the count while ticks keep arriving.
- R6: Mode 01 counts from 0x0000 up to 0xFFFF and then wraps to 0x0000. `ovf_o` pulses for one cycle on the wrap.
- R7: Mode 10 counts up to `period_i`. The next update returns the count to 0x0000 and pulses `ovf_o`.
- R8: Mode 11 counts up to `period_i` and then down to 0x0000. `ovf_o` pulses when the count reaches zero on the way down. Counting then resumes upward.
- R9: In modes 10 and 11, a `period_i` of 0x0000 keeps the count at 0x0000 and pulses `ovf_o` on every counter update.
- R10: The prescaler divider is cleared by a low-byte write. It advances only while the mode is not 00.
- R11: Whenever `ovf_o` is high, the count reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Tick enable that feeds the prescaler |
| addr_i | input | 2 | Register address: 0 control, 1 count low, 2 count high |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected address |
| period_i | input | 16 | Period value for the modulo and up/down modes |
| ovf_o | output | 1 | One-cycle terminal-count / overflow pulse |
| reinit_o | output | 1 | One-cycle channel reinitialise strobe |

## Verification
A wrong prescaler divider state appears at the ports as a count that is one update early or late. It shows on the first update after the fault, within at most 128 ticks. A wrong direction bit in up/down mode shows on the next update as a count that moves the wrong way, and as `ovf_o` pulses that are missing or extra. A bad high-byte buffer appears only on the next high-byte read. The bench therefore reads the high byte after the count has moved on since the low-byte read.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef enum logic [1:0] {
    MD_STOP = 2'b00,
    MD_FREE = 2'b01,
    MD_MOD  = 2'b10,
    MD_UPDN = 2'b11
  } tmr_mode_e;

  localparam logic [1:0] AD_CTRL = 2'd0;
  localparam logic [1:0] AD_CNTL = 2'd1;
  localparam logic [1:0] AD_CNTH = 2'd2;

endpackage

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
  parameter int SH1 = 3,
  parameter int SH2 = 5,
  parameter int SH3 = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic       clr_i,
  input  logic [1:0] sel_i,
  output logic       upd_o
);

  localparam int PS_W = SH3;

  logic [PS_W-1:0] div_q, div_d;
  logic [PS_W-1:0] lim;
  logic            at_lim;
  logic            adv;

  always_comb begin
    case (sel_i)
      2'b00:   lim = '0;
      2'b01:   lim = PS_W'((1 << SH1) - 1);
      2'b10:   lim = PS_W'((1 << SH2) - 1);
      default: lim = PS_W'((1 << SH3) - 1);
    endcase
  end

  assign at_lim = (div_q >= lim);
  assign adv    = run_i && tick_i && !clr_i;

  always_comb begin
    div_d = div_q;
    if (clr_i)
      div_d = '0;
    else if (adv)
      div_d = at_lim ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      div_q <= '0;
    else
      div_q <= div_d;
  end

  assign upd_o = adv && at_lim;

  AST_DIV_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (div_q == '0)); // R10
  AST_DIV_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(div_q)); // R10

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             clr_i,
  input  tmr_mode_e        mode_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             down_q, down_d;
  logic             ovf_q, ovf_d;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    ovf_d  = 1'b0;
    if (clr_i) begin
      cnt_d  = '0;
      down_d = 1'b0;
    end else begin
      if (mode_i != MD_UPDN)
        down_d = 1'b0;
      if (upd_i) begin
        case (mode_i)
          MD_FREE: begin
            cnt_d = cnt_q + CNT_ONE;
            ovf_d = (cnt_q == CNT_MAX);
          end
          MD_MOD: begin
            if (cnt_q >= period_i) begin
              cnt_d = '0;
              ovf_d = 1'b1;
            end else begin
              cnt_d = cnt_q + CNT_ONE;
            end
          end
          MD_UPDN: begin
            if (period_i == '0) begin
              cnt_d  = '0;
              ovf_d  = 1'b1;
              down_d = 1'b0;
            end else if (down_q) begin
              if (cnt_q <= CNT_ONE) begin
                cnt_d  = '0;
                ovf_d  = 1'b1;
                down_d = 1'b0;
              end else begin
                cnt_d = cnt_q - CNT_ONE;
              end
            end else if (cnt_q >= period_i) begin
              cnt_d  = cnt_q - CNT_ONE;
              down_d = 1'b1;
            end else begin
              cnt_d = cnt_q + CNT_ONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
      ovf_q  <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R3
  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_STOP && !clr_i) |=> $stable(cnt_q)); // R5
  AST_OVF_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> (cnt_q == '0)); // R11
  AST_MOD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_MOD && upd_i && !clr_i && cnt_q < period_i)
      |=> (cnt_q == $past(cnt_q) + CNT_ONE)); // R7
  AST_NO_UPD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !clr_i) |=> ($stable(cnt_q) && !ovf_q)); // R4

endmodule

// File: rtl/tmr16_regif.sv
module tmr16_regif
  import tmr16_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] rdata_o,
  output tmr_mode_e         mode_o,
  output logic [1:0]        div_o,
  output logic              clr_o,
  output logic              reinit_o
);

  localparam int CTRL_W = 4;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] hbuf_q, hbuf_d;
  logic              reinit_q, reinit_d;
  logic              wr_ctrl, wr_cntl, rd_cntl;

  assign wr_ctrl = wr_i && (addr_i == AD_CTRL);
  assign wr_cntl = wr_i && (addr_i == AD_CNTL);
  assign rd_cntl = rd_i && (addr_i == AD_CNTL);

  always_comb begin
    ctrl_d   = ctrl_q;
    hbuf_d   = hbuf_q;
    reinit_d = wr_cntl;
    if (wr_ctrl)
      ctrl_d = wdata_i[CTRL_W-1:0];
    if (rd_cntl)
      hbuf_d = cnt_i[CNT_W-1 -: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      hbuf_q   <= '0;
      reinit_q <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      hbuf_q   <= hbuf_d;
      reinit_q <= reinit_d;
    end
  end

  always_comb begin
    case (addr_i)
      AD_CTRL: rdata_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      AD_CNTL: rdata_o = cnt_i[DATA_W-1:0];
      AD_CNTH: rdata_o = hbuf_q;
      default: rdata_o = '0;
    endcase
  end

  assign mode_o   = tmr_mode_e'(ctrl_q[1:0]);
  assign div_o    = ctrl_q[3:2];
  assign clr_o    = wr_cntl;
  assign reinit_o = reinit_q;

  AST_CTRL_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == AD_CTRL) |-> (rdata_o[DATA_W-1:CTRL_W] == '0)); // R1
  AST_HBUF_SNAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cntl |=> (hbuf_q == $past(cnt_i[CNT_W-1 -: DATA_W]))); // R2
  AST_HBUF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_cntl |=> $stable(hbuf_q)); // R2
  AST_REINIT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cntl |=> reinit_q); // R3

endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
  import tmr16_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SH1    = 3,
  parameter int SH2    = 5,
  parameter int SH3    = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [1:0]          addr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [2*DATA_W-1:0] period_i,
  output logic                ovf_o,
  output logic                reinit_o
);

  localparam int CNT_W = 2 * DATA_W;

  logic             rst_meta_q, rst_sync_q;
  logic [CNT_W-1:0] cnt;
  tmr_mode_e        mode;
  logic [1:0]       div;
  logic             clr;
  logic             upd;
  logic             run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign run = (mode != MD_STOP);

  tmr16_regif #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regif (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_q),
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .wdata_i  (wdata_i),
    .cnt_i    (cnt),
    .rdata_o  (rdata_o),
    .mode_o   (mode),
    .div_o    (div),
    .clr_o    (clr),
    .reinit_o (reinit_o)
  );

  tmr16_prescale #(.SH1(SH1), .SH2(SH2), .SH3(SH3)) u_prescale (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_q),
    .tick_i (tick_i),
    .run_i  (run),
    .clr_i  (clr),
    .sel_i  (div),
    .upd_o  (upd)
  );

  tmr16_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_q),
    .upd_i    (upd),
    .clr_i    (clr),
    .mode_i   (mode),
    .period_i (period_i),
    .cnt_o    (cnt),
    .ovf_o    (ovf_o)
  );

endmodule

// File: tb/tb_tmr16_top.sv
module tb_tmr16_top;

  logic        clk;
  logic        rst_n;
  logic        tick;
  logic [1:0]  addr;
  logic        wr;
  logic        rd;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [15:0] period;
  logic        ovf;
  logic        reinit;

  int n_cmp = 0;
  int n_bad = 0;
  int ovf_seen;

  tmr16_top dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .tick_i   (tick),
    .addr_i   (addr),
    .wr_i     (wr),
    .rd_i     (rd),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .period_i (period),
    .ovf_o    (ovf),
    .reinit_o (reinit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  div;
    logic [15:0] per;
    logic [15:0] ticks;
    logic [15:0] exp_cnt;
    logic [7:0]  exp_ovf;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 2'b00, 16'd0, 16'd10,  16'd10, 8'd0},
    '{2'b01, 2'b01, 16'd0, 16'd20,  16'd2,  8'd0},
    '{2'b10, 2'b00, 16'd4, 16'd12,  16'd2,  8'd2},
    '{2'b11, 2'b00, 16'd3, 16'd10,  16'd2,  8'd1},
    '{2'b10, 2'b00, 16'd0, 16'd5,   16'd0,  8'd5},
    '{2'b11, 2'b00, 16'd0, 16'd4,   16'd0,  8'd4},
    '{2'b00, 2'b00, 16'd9, 16'd6,   16'd0,  8'd0},
    '{2'b10, 2'b10, 16'd1, 16'd100, 16'd1,  8'd1},
    '{2'b11, 2'b11, 16'd5, 16'd300, 16'd2,  8'd0}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic read_cnt(output logic [15:0] c);
    logic [7:0] lo, hi;
    bus_rd(2'd1, lo);
    bus_rd(2'd2, hi);
    c = {hi, lo};
  endtask

  task automatic run_ticks(input int n);
    ovf_seen = 0;
    @(negedge clk);
    tick = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ovf) ovf_seen++;
    end
    tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] c;
    rst_n = 1'b0; tick = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0;
    wdata = '0; period = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 ovf after reset", ovf, 0);
    check("R3 reinit after reset", reinit, 0);
    bus_rd(2'd0, b);
    check("R1 ctrl reset", b, 8'h00);
    read_cnt(c);
    check("R2 count reset", c, 16'h0000);
    bus_wr(2'd0, 8'hFF);
    bus_rd(2'd0, b);
    check("R1 reserved bits zero", b, 8'h0F);

    // vector table: R4 R6 R7 R8 R9 R5
    foreach (VECS[k]) begin
      period = VECS[k].per;
      bus_wr(2'd0, {4'h0, VECS[k].div, VECS[k].mode});
      bus_wr(2'd1, 8'h00);
      run_ticks(int'(VECS[k].ticks));
      read_cnt(c);
      check($sformatf("R4/R7/R8/R9 vec %0d count", k), c, VECS[k].exp_cnt);
      check($sformatf("R6/R7/R8/R9 vec %0d ovf pulses", k), ovf_seen, VECS[k].exp_ovf);
    end

    // R3 clear strobe with non-zero data
    bus_wr(2'd0, 8'h01);
    bus_wr(2'd1, 8'h00);
    run_ticks(7);
    @(negedge clk);
    addr = 2'd1; wdata = 8'h5A; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    check("R3 reinit pulse", reinit, 1);
    @(negedge clk);
    check("R3 reinit one cycle", reinit, 0);
    read_cnt(c);
    check("R3 count cleared", c, 16'h0000);

    // R5 hold and R3 high-byte write ignored
    run_ticks(3);
    bus_wr(2'd0, 8'h00);
    run_ticks(5);
    read_cnt(c);
    check("R5 stop holds", c, 16'd3);
    bus_wr(2'd2, 8'h77);
    read_cnt(c);
    check("R3 high write ignored", c, 16'd3);

    // R10 divider cleared by low write
    bus_wr(2'd0, 8'h05);
    bus_wr(2'd1, 8'h00);
    run_ticks(5);
    bus_wr(2'd1, 8'h00);
    run_ticks(5);
    read_cnt(c);
    check("R10 divider cleared", c, 16'd0);
    run_ticks(3);
    read_cnt(c);
    check("R10 update after 8", c, 16'd1);

    // R10 divider frozen while stopped
    bus_wr(2'd0, 8'h04);
    bus_wr(2'd1, 8'h00);
    run_ticks(10);
    bus_wr(2'd0, 8'h05);
    run_ticks(7);
    read_cnt(c);
    check("R10 no advance in stop", c, 16'd0);
    run_ticks(1);
    read_cnt(c);
    check("R10 eighth tick", c, 16'd1);

    // R6 full wrap and R2 buffered high byte
    bus_wr(2'd0, 8'h01);
    bus_wr(2'd1, 8'h00);
    run_ticks(65535);
    check("R6 no ovf before wrap", ovf_seen, 0);
    bus_rd(2'd1, b);
    check("R6 low at max", b, 8'hFF);
    run_ticks(1);
    check("R6 ovf on wrap", ovf_seen, 1);
    bus_rd(2'd2, b);
    check("R2 high from snapshot", b, 8'hFF);
    read_cnt(c);
    check("R6 wrapped to zero", c, 16'h0000);
    check("R11 ovf idle", ovf, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule